// File: doc/BRIEF.md
# Priority Transmit Request Queue

This block holds pending transmit requests for a CAN controller and presents one of them as the active frame to the serializer. Each request carries an 11-bit identifier, a 4-bit length code and eight payload bytes. A lower identifier means higher priority.

Waiting requests sit in a queue of `N` slots. The queue is kept in ascending identifier order, so its head is always the best candidate. A separate active register holds the frame that is currently being sent.

A write places a new request. It goes straight into the active register when that register is free. It displaces the active frame when its identifier is lower. Otherwise it joins the queue. A read signals that the current transmission has finished and promotes the queue head. Arbitration on the wire and serialization are handled elsewhere.

Top module: `tx_prio_queue`

## Requirements
- R1: Queued entries are ordered by ascending identifier. Entries with equal identifiers are served in the order they entered the queue, and a newly queued entry goes behind every entry that has the same identifier.
- R2: A write while the active register is empty loads the request into the active register. The new frame is visible on the outputs one cycle later.
- R3: A write whose identifier is greater than or equal to the active identifier leaves the active frame unchanged and places the request in the queue.
- R4: A write whose identifier is strictly lower than the active identifier makes the request active one cycle later. The displaced frame is put back into the queue at its sorted position, behind any entries with the same identifier.
- R5: A read while the queue is not empty moves the lowest-identifier entry into the active register one cycle later and shortens the queue by one.
- R6: A read while the queue is empty leaves the active register invalid one cycle later.
- R7: `full_o` is high exactly when `N` entries are queued, not counting the active frame. A write while full, with no read in the same cycle, changes neither the active frame nor the queue.
- R8: `empty_o` is high exactly when the queue holds no entries and the active register holds no valid frame.
- R9: `start_tx_o` is high exactly when the active register holds a valid frame.
- R10: When a write and a read arrive in the same cycle, the read is applied first. The write is then judged, including the full test, against the state the read leaves behind.
- R11: After reset, `start_tx_o` and `full_o` are low and `empty_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write a new request |
| req_id_i | input | 11 | Identifier of the new request |
| req_dlc_i | input | 4 | Length code of the new request |
| req_data_i | input | 64 | Payload of the new request, byte 0 in bits 7:0 |
| re_i | input | 1 | Current transmission finished; promote the next entry |
| start_tx_o | output | 1 | Active register holds a valid frame |
| tx_id_o | output | 11 | Active frame identifier |
| tx_dlc_o | output | 4 | Active frame length code |
| tx_data_o | output | 64 | Active frame payload |
| full_o | output | 1 | Queue holds N entries |
| empty_o | output | 1 | Queue and active register both empty |

## Verification
The bench runs a configuration with four queue slots. It writes every ordering of four distinct identifiers plus a fifth that is lower than all of them, then drains the queue. This separates correct sorted insertion and preemption from plain arrival order.

A long pseudo-random mix of writes, reads and combined write-read cycles follows. It draws from only eight identifiers, so many requests tie. The tagged payload of each request shows whether equal identifiers keep their queue order, and the combined cycles expose a write that is judged before the read instead of after it.

Directed sequences cover the single-cycle edges: writing into an idle register, a write rejected while full, a read with nothing queued, and the reset state.

// File: rtl/txq_pkg.sv
package txq_pkg;
  parameter int unsigned ID_W          = 11;
  parameter int unsigned DLC_W         = 4;
  parameter int unsigned PAYLOAD_BYTES = 8;
  localparam int unsigned DATA_W       = PAYLOAD_BYTES * 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/tx_prio_rank.sv
module tx_prio_rank import txq_pkg::*; #(
  parameter int unsigned N  = 8,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  frame_t          ent_i [N],
  input  logic [CW-1:0]   cnt_i,
  input  logic [ID_W-1:0] key_i,
  output logic [CW-1:0]   pos_o
);
  // slot index = number of valid entries with id <= key (ties go behind)
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < N; i++) begin
      if ((CW'(i) < cnt_i) && (ent_i[i].id <= key_i)) pos_o = pos_o + CW'(1);
    end
  end
endmodule

// File: rtl/tx_prio_store.sv
module tx_prio_store import txq_pkg::*; #(
  parameter int unsigned N  = 8,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          ins_i,
  input  logic [CW-1:0] ins_pos_i,
  input  frame_t        ins_frame_i,
  output frame_t        head_o,
  output logic [CW-1:0] cnt_o,
  output frame_t        ent_pop_o [N],
  output logic [CW-1:0] cnt_pop_o
);
  frame_t        ent_q [N];
  frame_t        ent_d [N];
  logic [CW-1:0] cnt_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (pop_i && (i < N - 1)) ent_pop_o[i] = ent_q[(i < N - 1) ? i + 1 : i];
      else                      ent_pop_o[i] = ent_q[i];
    end
    cnt_pop_o = cnt_q - CW'(pop_i);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!ins_i || (CW'(i) < ins_pos_i)) ent_d[i] = ent_pop_o[i];
      else if (CW'(i) == ins_pos_i)       ent_d[i] = ins_frame_i;
      else                                ent_d[i] = ent_pop_o[(i == 0) ? 0 : i - 1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
      cnt_q <= cnt_pop_o + CW'(ins_i);
    end
  end

  assign head_o = ent_q[0];
  assign cnt_o  = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> (cnt_pop_o < CW'(N)));

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(N)) |=> (cnt_q >= CW'(N - 1)));

  for (genvar g = 0; g < N - 1; g++) begin : g_order
    assert_sorted_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CW'(g + 1) < cnt_q) |-> (ent_q[g].id <= ent_q[g+1].id));
  end
endmodule

// File: rtl/tx_prio_queue.sv
module tx_prio_queue import txq_pkg::*; #(
  parameter int unsigned N  = 8,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [DLC_W-1:0]  req_dlc_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              re_i,
  output logic              start_tx_o,
  output logic [ID_W-1:0]   tx_id_o,
  output logic [DLC_W-1:0]  tx_dlc_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              full_o,
  output logic              empty_o
);
  frame_t        act_q, act_rd, act_d, req, ins_frame, head;
  logic          act_v_q, act_v_rd, act_v_d;
  logic          pop, ins, wr_ok;
  logic [CW-1:0] cnt, cnt_pop, ins_pos;
  frame_t        ent_pop [N];

  assign req = '{id: req_id_i, dlc: req_dlc_i, data: req_data_i};

  // read resolves first, write sees the post-read state
  always_comb begin
    pop       = re_i && (cnt != '0);
    act_rd    = pop ? head : act_q;
    act_v_rd  = re_i ? (cnt != '0) : act_v_q;
    wr_ok     = we_i && (cnt_pop < CW'(N));
    ins       = 1'b0;
    ins_frame = req;
    act_d     = act_rd;
    act_v_d   = act_v_rd;
    if (wr_ok) begin
      if (!act_v_rd) begin
        act_d   = req;
        act_v_d = 1'b1;
      end else if (req.id < act_rd.id) begin
        ins       = 1'b1;
        ins_frame = act_rd;
        act_d     = req;
      end else begin
        ins = 1'b1;
      end
    end
  end

  tx_prio_store #(.N(N)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop),
    .ins_i       (ins),
    .ins_pos_i   (ins_pos),
    .ins_frame_i (ins_frame),
    .head_o      (head),
    .cnt_o       (cnt),
    .ent_pop_o   (ent_pop),
    .cnt_pop_o   (cnt_pop)
  );

  tx_prio_rank #(.N(N)) u_rank (
    .ent_i (ent_pop),
    .cnt_i (cnt_pop),
    .key_i (ins_frame.id),
    .pos_o (ins_pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      act_v_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      act_v_q <= act_v_d;
    end
  end

  assign start_tx_o = act_v_q;
  assign tx_id_o    = act_q.id;
  assign tx_dlc_o   = act_q.dlc;
  assign tx_data_o  = act_q.data;
  assign full_o     = (cnt == CW'(N));
  assign empty_o    = !act_v_q && (cnt == '0);

  assert_preempt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !re_i && start_tx_o && !full_o && (req_id_i < tx_id_o))
      |=> (start_tx_o && (tx_id_o == $past(req_id_i))));

  assert_full_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !re_i && full_o) |=> (full_o && $stable(tx_id_o) && $stable(tx_dlc_o)));

  assert_promote_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && (cnt != '0)) |=> (start_tx_o && (tx_id_o == $past(head.id))));

  assert_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && (cnt == '0)) |=> !start_tx_o);

  assert_head_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_tx_o && (cnt != '0)) |-> (tx_id_o <= head.id));
endmodule

// File: tb/tx_prio_queue_tb_top.sv
`timescale 1ns/1ps
module tx_prio_queue_tb_top;
  import txq_pkg::*;
  localparam int BN = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic we_i = 1'b0, re_i = 1'b0;
  logic [ID_W-1:0]   req_id_i = '0;
  logic [DLC_W-1:0]  req_dlc_i = '0;
  logic [DATA_W-1:0] req_data_i = '0;
  logic start_tx_o, full_o, empty_o;
  logic [ID_W-1:0]   tx_id_o;
  logic [DLC_W-1:0]  tx_dlc_o;
  logic [DATA_W-1:0] tx_data_o;

  always #2 clk_i = ~clk_i;

  tx_prio_queue #(.N(BN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .req_id_i(req_id_i),
    .req_dlc_i(req_dlc_i), .req_data_i(req_data_i), .re_i(re_i),
    .start_tx_o(start_tx_o), .tx_id_o(tx_id_o), .tx_dlc_o(tx_dlc_o),
    .tx_data_o(tx_data_o), .full_o(full_o), .empty_o(empty_o)
  );

  int checks = 0, errors = 0, seq = 0;
  bit done = 0;
  frame_t mq [BN];
  int     mcnt = 0;
  frame_t mact;
  bit     mav = 0;

  function automatic void m_insert(frame_t f);
    int pos = 0;
    for (int i = 0; i < mcnt; i++) if (mq[i].id <= f.id) pos++;
    for (int i = BN - 1; i > pos; i--) mq[i] = mq[i-1];
    mq[pos] = f;
    mcnt++;
  endfunction

  task automatic check_out(string tag);
    bit ok;
    checks++;
    ok = (start_tx_o === mav) && (full_o === (mcnt == BN)) &&
         (empty_o === (!mav && mcnt == 0));
    if (mav) ok = ok && (tx_id_o === mact.id) && (tx_dlc_o === mact.dlc) && (tx_data_o === mact.data);
    if (!ok) begin
      errors++;
      $display("FAIL %s actual start=%0b full=%0b empty=%0b id=%0d dlc=%0d data=%h expected start=%0b full=%0b empty=%0b id=%0d dlc=%0d data=%h",
               tag, start_tx_o, full_o, empty_o, tx_id_o, tx_dlc_o, tx_data_o,
               mav, (mcnt == BN), (!mav && mcnt == 0), mact.id, mact.dlc, mact.data);
    end
  endtask

  task automatic step(bit we, int id, bit re, string tag);
    frame_t f;
    seq++;
    f.id   = ID_W'(id);
    f.dlc  = DLC_W'(seq);
    f.data = {PAYLOAD_BYTES{8'(seq)}};
    we_i = we; re_i = re;
    req_id_i = f.id; req_dlc_i = f.dlc; req_data_i = f.data;
    if (re) begin
      if (mcnt > 0) begin
        mact = mq[0];
        for (int i = 0; i < BN - 1; i++) mq[i] = mq[i+1];
        mcnt--;
        mav = 1;
      end else mav = 0;
    end
    if (we && mcnt < BN) begin
      if (!mav) begin mact = f; mav = 1; end
      else if (f.id < mact.id) begin m_insert(mact); mact = f; end
      else m_insert(f);
    end
    @(posedge clk_i);
    #1 we_i = 0; re_i = 0;
    @(negedge clk_i);
    check_out(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ids [4];
    logic [15:0] lfsr;
    mact = '0;
    repeat (3) @(negedge clk_i);
    check_out("R11");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R11");

    step(1, 100, 0, "R2");
    step(1, 200, 0, "R3");
    step(1, 100, 0, "R3");
    step(1, 50,  0, "R4");
    step(0, 0, 1, "R4");   // displaced 100 goes behind queued 100
    step(0, 0, 1, "R1");
    step(0, 0, 1, "R5");
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R6");

    step(1, 10, 0, "R2");
    step(1, 40, 0, "R9");
    step(1, 30, 0, "R3");
    step(1, 20, 0, "R3");
    step(1, 35, 0, "R7");
    step(1, 1,  0, "R7");  // rejected while full
    step(1, 5,  1, "R10"); // pop 20, then 5 preempts it
    for (int k = 0; k < 6; k++) step(0, 0, 1, "R5");
    step(0, 0, 0, "R8");

    // every ordering of four ids, then a fifth lower one, then drain
    for (int p = 0; p < 24; p++) begin
      int pool [4] = '{10, 20, 30, 40};
      int r = p;
      int avail = 4;
      for (int s = 0; s < 4; s++) begin
        int fct = (avail == 4) ? 6 : (avail == 3) ? 2 : 1;
        int sel = r / fct;
        r = r % fct;
        ids[s] = pool[sel];
        for (int t = sel; t < 3; t++) pool[t] = pool[t+1];
        avail--;
      end
      for (int s = 0; s < 4; s++) step(1, ids[s], 0, "R1");
      step(1, 5, 0, "R4");
      for (int s = 0; s < 6; s++) step(0, 0, 1, "R5");
    end

    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], int'(lfsr[6:4]), lfsr[2] & lfsr[3], "R1");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule